// File: doc/BRIEF.md
# Parallel Video Timing Generator

This block drives the timing of a parallel RGB panel. It produces horizontal sync, vertical sync, data-enable and the pixel coordinates inside the active window. The horizontal and vertical timing words and the panel-size word are static configuration inputs. Each timing word packs a sync width, a back porch and a front porch. The panel-size word packs the active width and height.

Every line runs through sync, back porch, active and front porch, in that order. Every frame runs through the same four phases, counted in lines. Configuration is captured only when a frame starts, so a change made mid-frame takes effect cleanly at the next frame.

The block also produces three flags:
- a one-clock event at the start of vertical sync, for the interrupt unit;
- a one-clock underflow pulse whenever the pixel source is not ready during active video;
- a static warning when the vertical blanking ahead of active video is shorter than 32 lines.

An enabled halt request stops the raster at the next frame boundary. While halted, every output stays low.

Top module: `pvt_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0.
- R2: The horizontal timing word holds the sync width in bits 7:0, the back porch in bits 19:8 and the front porch in bits 31:20. `hsync_o` is high (active-high) for the first sync-width clocks of each line.
- R3: The vertical timing word uses the same packing, counted in lines. `vsync_o` is high for every clock of the first sync-width lines of each frame.
- R4: The panel-size word holds the active width in bits 15:0 and the active height in bits 31:16. `de_o` is high exactly when the horizontal position is inside the active window and the vertical position is inside the active window. Each window starts after sync plus back porch and lasts for the active size.
- R5: While `de_o` is high, `x_o`/`y_o` give the zero-based column and row within the active window. Outside it they are 0.
- R6: `vsync_evt_o` pulses for one clock at the first clock of each frame's vertical sync. It does not pulse when the vertical sync width is 0.
- R7: `underflow_o` pulses high one clock after each clock in which `de_o` was high and `src_valid_i` was low. Otherwise it is low.
- R8: While the raster runs, `cfg_warn_o` is high exactly when the captured vertical sync width plus the vertical back porch is below 32.
- R9: The timing and size inputs are captured only when the raster starts, which is after reset or after a halt, and at each frame boundary. Changes made within a frame do not affect that frame.
- R10: When `halt_en_i` and `halt_req_i` are both high at the end of the last clock of a frame, the raster stops and all outputs read 0. It restarts at coordinate (0,0) on the clock after the request drops.
- R11: When `halt_en_i` is low, `halt_req_i` has no effect and frames continue back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_timing_i | input | 32 | Horizontal sync width / back porch / front porch |
| v_timing_i | input | 32 | Vertical sync lines / back porch / front porch |
| panel_size_i | input | 32 | Active width (15:0), active height (31:16) |
| halt_en_i | input | 1 | Enables the halt function |
| halt_req_i | input | 1 | Requests a stop at the next frame boundary |
| src_valid_i | input | 1 | Pixel source ready |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| x_o | output | 16 | Active column |
| y_o | output | 16 | Active row |
| vsync_evt_o | output | 1 | One-clock event at the start of vertical sync |
| underflow_o | output | 1 | One-clock underflow pulse |
| cfg_warn_o | output | 1 | Vertical blanking shorter than 32 lines |

## Verification
The hardest situation to reach is a timing change that lands in the middle of a frame. It must be ignored until the exact boundary clock, and then combine correctly with a halt request or a restart. The stimulus uses tiny frames of about a hundred clocks. It rewrites the timing words at arbitrary points within a frame and toggles the halt controls across several boundaries. A behavioural integer model in the bench predicts every output on every clock, so a capture one clock early or late shows up as a mismatch.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
    localparam int SYNC_W   = 8;
    localparam int PORCH_W  = 12;
    localparam int ACT_W    = 16;
    localparam int CNT_W    = 18;
    localparam int SYNC_LSB = 0;
    localparam int BP_LSB   = 8;
    localparam int FP_LSB   = 20;
    localparam int AXES     = 2;

    typedef struct packed {
        logic [SYNC_W-1:0]  sync;
        logic [PORCH_W-1:0] bp;
        logic [ACT_W-1:0]   act;
        logic [PORCH_W-1:0] fp;
    } axis_cfg_t;
endpackage

// File: rtl/pvt_cfg_unpack.sv
module pvt_cfg_unpack
    import pvt_pkg::*;
(
    input  logic [31:0] timing_i,
    input  logic [ACT_W-1:0] act_i,
    output axis_cfg_t   cfg_o
);
    always_comb begin
        cfg_o.sync = timing_i[SYNC_LSB +: SYNC_W];
        cfg_o.bp   = timing_i[BP_LSB   +: PORCH_W];
        cfg_o.fp   = timing_i[FP_LSB   +: PORCH_W];
        cfg_o.act  = act_i;
    end
endmodule

// File: rtl/pvt_axis_decode.sv
module pvt_axis_decode
    import pvt_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_i,
    input  axis_cfg_t        cfg_i,
    output logic             in_sync_o,
    output logic             in_act_o,
    output logic [ACT_W-1:0] pos_o,
    output logic             last_o
);
    logic [CNT_W-1:0] start_w;
    logic [CNT_W-1:0] stop_w;
    logic [CNT_W-1:0] total_w;
    logic [CNT_W-1:0] rel_w;

    always_comb begin
        start_w   = CNT_W'(cfg_i.sync) + CNT_W'(cfg_i.bp);
        stop_w    = start_w + CNT_W'(cfg_i.act);
        total_w   = stop_w + CNT_W'(cfg_i.fp);
        in_sync_o = cnt_i < CNT_W'(cfg_i.sync);
        in_act_o  = (cnt_i >= start_w) && (cnt_i < stop_w);
        rel_w     = cnt_i - start_w;
        pos_o     = in_act_o ? rel_w[ACT_W-1:0] : '0;
        last_o    = (cnt_i + CNT_W'(1)) >= total_w;
    end
endmodule

// File: rtl/pvt_top.sv
module pvt_top
    import pvt_pkg::*;
#(
    parameter int MIN_VBLANK = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] h_timing_i,
    input  logic [31:0] v_timing_i,
    input  logic [31:0] panel_size_i,
    input  logic        halt_en_i,
    input  logic        halt_req_i,
    input  logic        src_valid_i,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic [15:0] x_o,
    output logic [15:0] y_o,
    output logic        vsync_evt_o,
    output logic        underflow_o,
    output logic        cfg_warn_o
);
    localparam int BLANK_W = PORCH_W + 1;

    typedef struct packed {
        logic                        running;
        logic                        underflow;
        axis_cfg_t [AXES-1:0]        cfg;
        logic [AXES-1:0][CNT_W-1:0]  cnt;
    } state_t;

    state_t state_d, state_q;
    axis_cfg_t [AXES-1:0] live_cfg;
    logic [AXES-1:0] in_sync, in_act, last;
    logic [AXES-1:0][ACT_W-1:0] pos;
    logic hold_w, de_w;
    logic [BLANK_W-1:0] vblank_w;

    pvt_cfg_unpack u_unpack_h (.timing_i(h_timing_i), .act_i(panel_size_i[15:0]),  .cfg_o(live_cfg[0]));
    pvt_cfg_unpack u_unpack_v (.timing_i(v_timing_i), .act_i(panel_size_i[31:16]), .cfg_o(live_cfg[1]));

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        pvt_axis_decode u_dec (
            .cnt_i     (state_q.cnt[g]),
            .cfg_i     (state_q.cfg[g]),
            .in_sync_o (in_sync[g]),
            .in_act_o  (in_act[g]),
            .pos_o     (pos[g]),
            .last_o    (last[g])
        );
    end

    always_comb begin
        hold_w = halt_en_i && halt_req_i;
        de_w   = state_q.running && in_act[0] && in_act[1];
        state_d = state_q;
        state_d.underflow = de_w && !src_valid_i;
        if (!state_q.running) begin
            if (!hold_w) begin
                state_d.running = 1'b1;
                state_d.cfg     = live_cfg;
                state_d.cnt     = '0;
            end
        end else if (last[0]) begin
            state_d.cnt[0] = '0;
            if (last[1]) begin
                state_d.cnt[1] = '0;
                if (hold_w) state_d.running = 1'b0;
                else        state_d.cfg     = live_cfg;
            end else begin
                state_d.cnt[1] = state_q.cnt[1] + CNT_W'(1);
            end
        end else begin
            state_d.cnt[0] = state_q.cnt[0] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        vblank_w    = BLANK_W'(state_q.cfg[1].sync) + BLANK_W'(state_q.cfg[1].bp);
        hsync_o     = state_q.running && in_sync[0];
        vsync_o     = state_q.running && in_sync[1];
        de_o        = de_w;
        x_o         = de_w ? pos[0] : '0;
        y_o         = de_w ? pos[1] : '0;
        vsync_evt_o = state_q.running && in_sync[1] && (state_q.cnt == '0);
        underflow_o = state_q.underflow;
        cfg_warn_o  = state_q.running && (vblank_w < BLANK_W'(MIN_VBLANK));
    end

    // R4: the active window never overlaps either sync phase
    p_de_outside_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (!hsync_o && !vsync_o));
    // R5: the column stays inside the captured active width
    p_x_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (x_o < state_q.cfg[0].act));
    // R6: the event only fires inside vertical sync
    p_evt_in_vsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_evt_o |-> (vsync_o && hsync_o));
    // R7: each pulse follows an active clock with the source not ready
    p_uf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $past(de_o && !src_valid_i));
    // R9: captured configuration is held except at a frame boundary
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.running && !(last[0] && last[1])) |=> $stable(state_q.cfg));
    // R10: a stopped raster drives nothing
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.running |-> (!de_o && !hsync_o && !vsync_o && !vsync_evt_o));
endmodule

// File: tb/pvt_top_tb.sv
module pvt_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [31:0] h_timing, v_timing, panel_size;
    logic halt_en = 1'b0, halt_req = 1'b0, src_valid = 1'b1;
    logic hsync, vsync, de, vevt, uf, warn;
    logic [15:0] x, y;

    int n_vec = 0, n_bad = 0, cycles = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_run = 0, m_h = 0, m_v = 0, m_uf = 0;
    int hs, hbp, ha, hfp, vs, vbp, va, vfp;
    int seen_de = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pvt_top u_dut (
        .clk(clk), .rst_n(rst_n), .h_timing_i(h_timing), .v_timing_i(v_timing),
        .panel_size_i(panel_size), .halt_en_i(halt_en), .halt_req_i(halt_req),
        .src_valid_i(src_valid), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
        .x_o(x), .y_o(y), .vsync_evt_o(vevt), .underflow_o(uf), .cfg_warn_o(warn)
    );

    function automatic logic [31:0] pack_t(int s, int b, int f);
        return (32'(f) << 20) | (32'(b) << 8) | 32'(s);
    endfunction

    task automatic capture();
        hs = h_timing[7:0];  hbp = h_timing[19:8]; hfp = h_timing[31:20];
        vs = v_timing[7:0];  vbp = v_timing[19:8]; vfp = v_timing[31:20];
        ha = panel_size[15:0]; va = panel_size[31:16];
    endtask

    function automatic bit m_de();
        return m_run != 0 && m_h >= hs + hbp && m_h < hs + hbp + ha
                          && m_v >= vs + vbp && m_v < vs + vbp + va;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_h = 0; m_v = 0; m_uf = 0;
        end else begin
            bit hold;
            hold = halt_en && halt_req;
            m_uf = (m_de() && !src_valid) ? 1 : 0;
            if (m_run == 0) begin
                if (!hold) begin m_run = 1; m_h = 0; m_v = 0; capture(); end
            end else if (m_h + 1 >= hs + hbp + ha + hfp) begin
                m_h = 0;
                if (m_v + 1 >= vs + vbp + va + vfp) begin
                    m_v = 0;
                    if (hold) m_run = 0; else capture();
                end else m_v++;
            end else m_h++;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        int e_hs, e_vs, e_de, e_x, e_y, e_ev, e_w;
        cycles++;
        e_de = m_de();
        e_hs = (m_run != 0 && m_h < hs) ? 1 : 0;
        e_vs = (m_run != 0 && m_v < vs) ? 1 : 0;
        e_x  = e_de ? m_h - hs - hbp : 0;
        e_y  = e_de ? m_v - vs - vbp : 0;
        e_ev = (m_run != 0 && m_v == 0 && m_h == 0 && vs > 0) ? 1 : 0;
        e_w  = (m_run != 0 && vs + vbp < 32) ? 1 : 0;
        if (!rst_n) begin
            chk(!hsync && !vsync && !de && x == 0 && y == 0 && !vevt && !uf && !warn,
                "R1 reset outputs", int'(de), 0);
        end else if (!done) begin
            if (de) seen_de = 1;
            chk(int'(hsync) == e_hs, "R2 hsync", int'(hsync), e_hs);
            chk(int'(vsync) == e_vs, "R3 vsync", int'(vsync), e_vs);
            chk(int'(de) == e_de, "R4 de", int'(de), e_de);
            chk(int'(x) == e_x, "R5 x", int'(x), e_x);
            chk(int'(y) == e_y, "R5 y", int'(y), e_y);
            chk(int'(vevt) == e_ev, "R6 vsync event", int'(vevt), e_ev);
            chk(int'(uf) == m_uf, "R7 underflow", int'(uf), m_uf);
            chk(int'(warn) == e_w, "R8 config warning", int'(warn), e_w);
        end
        if (cycles > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            src_valid = ($urandom_range(0, 3) != 0);
        end
    endtask

    initial begin
        h_timing   = pack_t(2, 3, 2);
        v_timing   = pack_t(2, 3, 1);
        panel_size = {16'd3, 16'd4};
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after reset is still idle
        chk(!de && !hsync && !vsync, "R1 first cycle", int'(hsync), 0);
        tick(250);
        // R9: mid-frame rewrite, new width only from the next frame
        tick(40);
        h_timing   = pack_t(1, 2, 3);
        panel_size = {16'd2, 16'd5};
        tick(300);
        // R8: blanking exactly at the limit, then one below
        v_timing = pack_t(20, 12, 1);
        tick(900);
        v_timing = pack_t(20, 11, 2);
        tick(900);
        v_timing = pack_t(0, 2, 1);  // R6: no event with zero sync width
        tick(300);
        // R11: halt request without enable is ignored
        v_timing = pack_t(2, 3, 1);
        halt_req = 1'b1;
        seen_de  = 0;
        tick(300);
        chk(seen_de == 1, "R11 frames continue", seen_de, 1);
        // R10: enabled halt stops at the frame boundary
        halt_en = 1'b1;
        tick(200);
        seen_de = 0;
        tick(100);
        chk(seen_de == 0, "R10 halted raster", seen_de, 0);
        halt_req = 1'b0;
        tick(300);
        chk(seen_de == 1, "R10 restart", seen_de, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule